// File: doc/BRIEF.md
# Interrupt Message to Indicator Bit Setter

This block sits between a device function's interrupt message window and system memory. Each message write carries a vector number in its low data bits. The block turns the write into two bit-set operations on memory. The first sets one bit in a per-vector indicator array. The second sets one bit in a summary array that is shared by all vectors of the adapter. Each bit-set is an atomic OR on a single byte. It is done as a locked byte read followed by a locked byte write of the old value OR the mask. Bits are numbered from the most significant bit of each byte.

An adapter interrupt, tagged with the function's interruption subclass, is raised toward the processor only when the summary byte read back as zero. If it was nonzero, an earlier interrupt is still pending service and no new one is needed. A memory access that reports an error posts an error event. Reads of the message window return all ones. Writes that arrive while the function is not enabled are consumed and dropped. A new message is held off until both bit-sets of the current one have finished.

Top module: `msi_ind_setter`

## Requirements
- R1: Out of reset, msg_ready is 1 and mem_req, irq_valid, err_evt and rd_valid are 0.
- R2: The vector number is msg_data[VEC_W-1:0], and the upper data bits have no effect. The indicator bit position is P = ind_ofs + vector. The byte written is at ind_base + P/8, and the mask is 8'h80 >> (P mod 8).
- R3: The summary bit position is sum_ofs, independent of the vector. The byte is at sum_base + sum_ofs/8, and the mask is 8'h80 >> (sum_ofs mod 8).
- R4: A write accepted while fn_enabled is 0 causes no memory access, no interrupt and no error event, and msg_ready stays 1.
- R5: Each bit-set is a read (mem_we=0) followed by a write (mem_we=1) of old|mask to the same address. mem_lock is 1 on both accesses, and other bits of the byte are preserved.
- R6: Both indicator accesses complete before the first summary access is issued.
- R7: irq_valid pulses for one cycle, with irq_isc equal to the isc captured at acceptance. This happens only when the summary read returned 8'h00 and neither summary access reported mem_err.
- R8: An access with mem_err pulses err_evt. A failed read skips its write. An indicator failure still proceeds to the summary bit-set.
- R9: msg_ready is 0 from the cycle after acceptance until both bit-sets have finished, so no message is taken in that window.
- R10: A cycle with rd_req set is answered in the next cycle with rd_valid = 1 and rd_data all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fn_enabled | input | 1 | Function is in the enabled state |
| ind_base | input | ADDR_W | Indicator array byte base address |
| ind_ofs | input | OFS_W | Indicator bit offset |
| sum_base | input | ADDR_W | Summary array byte base address |
| sum_ofs | input | OFS_W | Summary bit offset |
| isc | input | ISC_W | Interruption subclass |
| msg_valid | input | 1 | Message write present |
| msg_data | input | DATA_W | Message write data |
| msg_ready | output | 1 | Block can take a message |
| rd_req | input | 1 | Read of the message window |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DATA_W | Read response data |
| mem_req | output | 1 | Memory byte access request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Byte is locked for read-modify-write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 8 | Read byte |
| mem_err | input | 1 | Access failed |
| irq_valid | output | 1 | Adapter interrupt pulse |
| irq_isc | output | ISC_W | Subclass of the interrupt |
| err_evt | output | 1 | Error event pulse |

## Verification
The bench targets several corner cases. The first is a vector whose position crosses into the next byte. A design that forgot the offset or reversed the bit order would set the wrong byte or bit. The second is a second vector landing in an already-marked byte. If the OR were replaced by a plain write, the earlier bit would be cleared. The third is a summary byte that is already nonzero, in either the same bit or a neighbouring bit. A design that tested only its own bit, or ignored the old value, would raise a spurious interrupt. The bench also injects errors on the indicator and on the summary accesses. A wrong design might issue a write after a failed read, abandon the summary step, or interrupt despite a failed summary. Finally, the bench checks disabled-function writes, back-pressure while busy, and the all-ones read response.

// File: rtl/msi_ind_pkg.sv
package msi_ind_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_IND_GO,
        SQ_IND_WAIT,
        SQ_SUM_GO,
        SQ_SUM_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_READ,
        EN_WRITE,
        EN_DONE
    } eng_state_e;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] TOP_BIT = 8'h80;

endpackage

// File: rtl/msi_bit_locator.sv
module msi_bit_locator #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned POS_W  = 17
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [POS_W-1:0]  pos,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        bit_mask
);
    import msi_ind_pkg::*;

    localparam int unsigned SHIFT = 3;

    logic [POS_W-1:0] byte_idx;

    always_comb begin
        byte_idx  = pos >> SHIFT;
        byte_addr = base + ADDR_W'(byte_idx);
        bit_mask  = TOP_BIT >> pos[SHIFT-1:0];
    end

endmodule

// File: rtl/msi_byte_rmw.sv
module msi_byte_rmw #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        mask,
    output logic              done,
    output logic [7:0]        old_byte,
    output logic              fail,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_err
);
    import msi_ind_pkg::*;

    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        mask;
        logic [7:0]        old;
        logic              fail;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        case (eng_q.st)
            EN_IDLE: begin
                if (start) begin
                    eng_d.st   = EN_READ;
                    eng_d.addr = addr;
                    eng_d.mask = mask;
                    eng_d.old  = '0;
                    eng_d.fail = 1'b0;
                end
            end
            EN_READ: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        eng_d.old  = 8'hFF;
                        eng_d.fail = 1'b1;
                        eng_d.st   = EN_DONE;
                    end else begin
                        eng_d.old = mem_rdata;
                        eng_d.st  = EN_WRITE;
                    end
                end
            end
            EN_WRITE: begin
                if (mem_ack) begin
                    eng_d.fail = mem_err;
                    eng_d.st   = EN_DONE;
                end
            end
            default: eng_d.st = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: EN_IDLE, addr: '0, mask: '0, old: '0, fail: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        mem_req   = (eng_q.st == EN_READ) || (eng_q.st == EN_WRITE);
        mem_we    = (eng_q.st == EN_WRITE);
        mem_lock  = mem_req;
        mem_addr  = eng_q.addr;
        mem_wdata = eng_q.old | eng_q.mask;
        done      = (eng_q.st == EN_DONE);
        old_byte  = eng_q.old;
        fail      = eng_q.fail;
    end

endmodule

// File: rtl/msi_ind_setter.sv
module msi_ind_setter #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_W  = 16,
    parameter int unsigned VEC_W  = 11,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ISC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fn_enabled,
    input  logic [ADDR_W-1:0] ind_base,
    input  logic [OFS_W-1:0]  ind_ofs,
    input  logic [ADDR_W-1:0] sum_base,
    input  logic [OFS_W-1:0]  sum_ofs,
    input  logic [ISC_W-1:0]  isc,
    input  logic              msg_valid,
    input  logic [DATA_W-1:0] msg_data,
    output logic              msg_ready,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_err,
    output logic              irq_valid,
    output logic [ISC_W-1:0]  irq_isc,
    output logic              err_evt
);
    import msi_ind_pkg::*;

    localparam int unsigned WIDEST  = (OFS_W > VEC_W) ? OFS_W : VEC_W;
    localparam int unsigned POS_W   = WIDEST + 1;
    localparam int unsigned N_LOC   = 2;
    localparam int unsigned LOC_IND = 0;
    localparam int unsigned LOC_SUM = 1;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] ind_addr;
        logic [7:0]        ind_mask;
        logic [ADDR_W-1:0] sum_addr;
        logic [7:0]        sum_mask;
        logic [ISC_W-1:0]  isc;
        logic              irq;
        logic              err;
        logic              rd_v;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ADDR_W-1:0] loc_base [N_LOC];
    logic [POS_W-1:0]  loc_pos  [N_LOC];
    logic [ADDR_W-1:0] loc_addr [N_LOC];
    logic [7:0]        loc_mask [N_LOC];

    logic              eng_start;
    logic [ADDR_W-1:0] eng_addr;
    logic [7:0]        eng_mask;
    logic              eng_done;
    logic [7:0]        eng_old;
    logic              eng_fail;

    always_comb begin
        loc_base[LOC_IND] = ind_base;
        loc_pos[LOC_IND]  = POS_W'(ind_ofs) + POS_W'(msg_data[VEC_W-1:0]);
        loc_base[LOC_SUM] = sum_base;
        loc_pos[LOC_SUM]  = POS_W'(sum_ofs);
    end

    for (genvar g = 0; g < N_LOC; g++) begin : g_loc
        msi_bit_locator #(
            .ADDR_W(ADDR_W),
            .POS_W (POS_W)
        ) u_loc (
            .base     (loc_base[g]),
            .pos      (loc_pos[g]),
            .byte_addr(loc_addr[g]),
            .bit_mask (loc_mask[g])
        );
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.irq  = 1'b0;
        seq_d.err  = 1'b0;
        seq_d.rd_v = rd_req;
        case (seq_q.st)
            SQ_IDLE: begin
                if (msg_valid && fn_enabled) begin
                    seq_d.ind_addr = loc_addr[LOC_IND];
                    seq_d.ind_mask = loc_mask[LOC_IND];
                    seq_d.sum_addr = loc_addr[LOC_SUM];
                    seq_d.sum_mask = loc_mask[LOC_SUM];
                    seq_d.isc      = isc;
                    seq_d.st       = SQ_IND_GO;
                end
            end
            SQ_IND_GO: seq_d.st = SQ_IND_WAIT;
            SQ_IND_WAIT: begin
                if (eng_done) begin
                    seq_d.err = eng_fail;
                    seq_d.st  = SQ_SUM_GO;
                end
            end
            SQ_SUM_GO: seq_d.st = SQ_SUM_WAIT;
            SQ_SUM_WAIT: begin
                if (eng_done) begin
                    seq_d.err = eng_fail;
                    seq_d.irq = !eng_fail && (eng_old == 8'h00);
                    seq_d.st  = SQ_IDLE;
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, ind_addr: '0, ind_mask: '0, sum_addr: '0,
                       sum_mask: '0, isc: '0, irq: 1'b0, err: 1'b0, rd_v: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        eng_start = (seq_q.st == SQ_IND_GO) || (seq_q.st == SQ_SUM_GO);
        eng_addr  = (seq_q.st == SQ_SUM_GO) ? seq_q.sum_addr : seq_q.ind_addr;
        eng_mask  = (seq_q.st == SQ_SUM_GO) ? seq_q.sum_mask : seq_q.ind_mask;
    end

    msi_byte_rmw #(
        .ADDR_W(ADDR_W)
    ) u_rmw (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .addr     (eng_addr),
        .mask     (eng_mask),
        .done     (eng_done),
        .old_byte (eng_old),
        .fail     (eng_fail),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_lock (mem_lock),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .mem_err  (mem_err)
    );

    always_comb begin
        msg_ready = (seq_q.st == SQ_IDLE);
        rd_valid  = seq_q.rd_v;
        rd_data   = seq_q.rd_v ? '1 : '0;
        irq_valid = seq_q.irq;
        irq_isc   = seq_q.isc;
        err_evt   = seq_q.err;
    end

endmodule

// File: rtl/msi_ind_setter_chk.sv
module msi_ind_setter_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fn_enabled,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_lock,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              irq_valid
);

    // R5: every access is made under the lock
    p_lock_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    // R5: a write starts only right after an acknowledged read of the same byte
    p_write_follows_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req && mem_we) |-> $past(mem_req && !mem_we && mem_ack) && $stable(mem_addr));

    // R5: a pending request keeps its address and direction
    p_req_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9: no message is taken while memory is busy
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !msg_ready);

    // R4: a write to a disabled function leaves the block idle
    p_disabled_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && !fn_enabled) |=> (msg_ready && !mem_req));

    // R7: interrupt is a single-cycle pulse
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    // R10: window read answered next cycle with all ones
    p_read_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rd_valid && (rd_data == '1)));

endmodule

bind msi_ind_setter msi_ind_setter_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fn_enabled(fn_enabled),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .irq_valid (irq_valid)
);

// File: tb/tb_msi_ind_setter.sv
module tb_msi_ind_setter;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned OFS_W  = 16;
    localparam int unsigned VEC_W  = 11;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ISC_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fn_enabled = 1'b0;
    logic [ADDR_W-1:0] ind_base = '0;
    logic [OFS_W-1:0]  ind_ofs = '0;
    logic [ADDR_W-1:0] sum_base = '0;
    logic [OFS_W-1:0]  sum_ofs = '0;
    logic [ISC_W-1:0]  isc = '0;
    logic              msg_valid = 1'b0;
    logic [DATA_W-1:0] msg_data = '0;
    logic              msg_ready;
    logic              rd_req = 1'b0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              mem_req, mem_we, mem_lock;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              mem_ack = 1'b0;
    logic [7:0]        mem_rdata = '0;
    logic              mem_err = 1'b0;
    logic              irq_valid;
    logic [ISC_W-1:0]  irq_isc;
    logic              err_evt;

    always #5 clk = ~clk;

    msi_ind_setter #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .VEC_W(VEC_W), .DATA_W(DATA_W), .ISC_W(ISC_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .fn_enabled(fn_enabled),
        .ind_base(ind_base), .ind_ofs(ind_ofs), .sum_base(sum_base), .sum_ofs(sum_ofs),
        .isc(isc), .msg_valid(msg_valid), .msg_data(msg_data), .msg_ready(msg_ready),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .irq_valid(irq_valid), .irq_isc(irq_isc), .err_evt(err_evt)
    );

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;

    logic [7:0]  mem [256];
    logic [7:0]  log_addr [16];
    logic        log_we   [16];
    logic        log_lock [16];
    int unsigned n_acc = 0;
    int unsigned n_irq = 0;
    int unsigned n_err = 0;
    logic [ISC_W-1:0] last_isc = '0;
    int unsigned busy_ready = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // memory responder: one-cycle ack, addresses at or above 0xF0 fail
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req) begin
                if (n_acc < 16) begin
                    log_addr[n_acc] = mem_addr[7:0];
                    log_we[n_acc]   = mem_we;
                    log_lock[n_acc] = mem_lock;
                end
                n_acc++;
                mem_err   = (mem_addr[7:0] >= 8'hF0);
                mem_rdata = mem[mem_addr[7:0]];
                if (mem_we && !mem_err) mem[mem_addr[7:0]] = mem_wdata;
                mem_ack = 1'b1;
            end
        end
    end

    // event monitor
    initial begin
        forever begin
            @(negedge clk);
            if (irq_valid) begin
                n_irq++;
                last_isc = irq_isc;
            end
            if (err_evt) n_err++;
            if (mem_req && msg_ready) busy_ready++;
        end
    end

    function automatic logic [7:0] exp_addr(input logic [7:0] base, input int unsigned pos);
        return base + 8'(pos >> 3);
    endfunction

    function automatic logic [7:0] exp_mask(input int unsigned pos);
        return 8'h80 >> (pos % 8);
    endfunction

    task automatic send(input logic [DATA_W-1:0] data, input bit expect_busy);
        @(negedge clk);
        while (!msg_ready) @(negedge clk);
        msg_valid = 1'b1;
        msg_data  = data;
        @(negedge clk);
        msg_valid = 1'b0;
        if (expect_busy) check(msg_ready == 1'b0, "R9 ready low after accept", msg_ready, 0);
        else             check(msg_ready == 1'b1, "R4 ready stays high", msg_ready, 1);
        repeat (2) @(negedge clk);
        while (!msg_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic t_reset();
        check(msg_ready == 1'b1, "R1 msg_ready", msg_ready, 1);
        check(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
        check(irq_valid == 1'b0 && err_evt == 1'b0, "R1 irq/err", {irq_valid, err_evt}, 0);
        check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    endtask

    task automatic t_basic();
        int unsigned a0 = n_acc, i0 = n_irq;
        fn_enabled = 1'b1;
        ind_base = 32'h10; ind_ofs = 16'd3;
        sum_base = 32'h40; sum_ofs = 16'd10;
        isc = 3'd5;
        send(32'hABCD_0005, 1'b1);  // R2: vector = low 11 bits = 5
        check(mem[exp_addr(8'h10, 8)] == exp_mask(8), "R2 indicator byte", mem[8'h11], 8'h80);
        check(mem[exp_addr(8'h40, 10)] == exp_mask(10), "R3 summary byte", mem[8'h41], 8'h20);
        check(n_irq == i0 + 1, "R7 irq on zero summary", n_irq - i0, 1);
        check(last_isc == 3'd5, "R7 irq subclass", last_isc, 5);
        check(n_acc == a0 + 4, "R5 four accesses", n_acc - a0, 4);
        check(log_addr[a0] == 8'h11 && !log_we[a0] && log_lock[a0], "R5 locked read first",
              {log_addr[a0], log_we[a0], log_lock[a0]}, {8'h11, 1'b0, 1'b1});
        check(log_addr[a0+1] == 8'h11 && log_we[a0+1] && log_lock[a0+1], "R5 locked write second",
              {log_addr[a0+1], log_we[a0+1], log_lock[a0+1]}, {8'h11, 1'b1, 1'b1});
        check(log_addr[a0+2] == 8'h41 && !log_we[a0+2] && log_addr[a0+3] == 8'h41 && log_we[a0+3],
              "R6 summary after indicator", {log_addr[a0+2], log_addr[a0+3]}, {8'h41, 8'h41});
        check(n_err == 0, "R8 no error event", n_err, 0);
    endtask

    task automatic t_or_and_pending();
        int unsigned i0 = n_irq;
        send(32'h0000_000C, 1'b1);  // position 15 -> byte 0x11 mask 0x01
        check(mem[8'h11] == 8'h81, "R5 OR keeps earlier bit", mem[8'h11], 8'h81);
        check(mem[8'h41] == 8'h20, "R3 summary unchanged", mem[8'h41], 8'h20);
        check(n_irq == i0, "R7 no irq when summary set", n_irq - i0, 0);
        mem[8'h42] = 8'h02;
        sum_ofs = 16'd17;           // byte 0x42 mask 0x40
        send(32'h0000_0001, 1'b1);
        check(mem[8'h42] == 8'h42, "R3 neighbouring summary bit", mem[8'h42], 8'h42);
        check(n_irq == i0, "R7 no irq when other summary bit set", n_irq - i0, 0);
    endtask

    task automatic t_disabled();
        int unsigned a0 = n_acc, i0 = n_irq, e0 = n_err;
        fn_enabled = 1'b0;
        send(32'h0000_0002, 1'b0);
        check(n_acc == a0, "R4 no memory access", n_acc - a0, 0);
        check(n_irq == i0 && n_err == e0, "R4 no irq or error", n_irq - i0 + n_err - e0, 0);
        fn_enabled = 1'b1;
    endtask

    task automatic t_errors();
        int unsigned a0, i0, e0;
        clear_mem();
        a0 = n_acc; i0 = n_irq; e0 = n_err;
        ind_base = 32'hF0; ind_ofs = 16'd0;
        sum_base = 32'h50; sum_ofs = 16'd0;
        isc = 3'd2;
        send(32'h0000_0000, 1'b1);
        check(n_err == e0 + 1, "R8 indicator error event", n_err - e0, 1);
        check(n_acc == a0 + 3, "R8 failed read skips write", n_acc - a0, 3);
        check(mem[8'h50] == 8'h80, "R8 summary still set", mem[8'h50], 8'h80);
        check(n_irq == i0 + 1 && last_isc == 3'd2, "R7 irq after indicator error",
              n_irq - i0, 1);
        a0 = n_acc; i0 = n_irq; e0 = n_err;
        ind_base = 32'h20; sum_base = 32'hF8;
        send(32'h0000_0009, 1'b1);
        check(mem[8'h21] == 8'h40, "R2 indicator set before summary error", mem[8'h21], 8'h40);
        check(n_err == e0 + 1, "R8 summary error event", n_err - e0, 1);
        check(n_irq == i0, "R7 no irq on summary error", n_irq - i0, 0);
    endtask

    task automatic t_read();
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_valid == 1'b1, "R10 read valid", rd_valid, 1);
        check(rd_data == '1, "R10 read all ones", rd_data, 32'hFFFF_FFFF);
        @(negedge clk);
        check(rd_valid == 1'b0, "R10 single response", rd_valid, 0);
    endtask

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_or_and_pending();
        t_disabled();
        t_errors();
        t_read();
        check(busy_ready == 0, "R9 never ready while busy", busy_ready, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule